// File: doc/BRIEF.md
# Byte-Serial Register Write Decoder

This block turns a stream of bytes on an 8-bit link into register write commands. A command is a fixed-length frame of bytes. The first byte arrives together with a one-cycle start flag. The first two bytes form a 16-bit target address, least significant byte first. The remaining bytes carry a data word, least significant byte first. After the final byte, the block compares the address against a set of address windows. Each window has its own base and mask. For every window that the address falls into, the block raises that window's write-enable bit for one clock. The low address bits and the data word are presented on the outputs at the same time.

The link has no back-pressure. A byte is offered on every clock, and the decoder accepts a byte whenever one is offered. Bytes that arrive outside a frame carry no meaning and are dropped. A start flag that arrives in the middle of a frame abandons that frame and starts a new one. The frame length is a parameter from 3 to 6 bytes. Shorter frames carry fewer data bytes, and the missing upper bytes of the data word read as zero. The block runs on one clock with a synchronous active-high reset.

Top module: `cmd_byte_decoder`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `wr_en`, `wr_addr` and `wr_data` are all zero.
- R2: Frame byte k is the byte sampled k clocks after the clock edge that samples `cmd_first`=1. Byte 0 is address[7:0] and byte 1 is address[15:8]. Byte 2+j is data[8j+7:8j], so byte 2 is the least significant data byte.
- R3: Window w matches when (address AND mask_w) equals (base_w AND mask_w). `wr_en[w]` pulses only for a frame whose address matches window w.
- R4: The windows are decoded independently. An address that matches several windows raises all of their enable bits in the same cycle.
- R5: A frame whose address matches no window leaves `wr_en` at zero.
- R6: Suppose the last byte of a frame is sampled at edge n. Then `wr_en` is high from edge n+1 to edge n+2 and low again after edge n+2. Each completed matching frame gives exactly one pulse, and back-to-back frames with no gap each give one pulse.
- R7: When `cmd_first` is sampled high before the current frame is complete, that frame is dropped without a pulse. This also applies on the cycle where the frame's last byte was due. The flagged byte becomes byte 0 of a new frame.
- R8: Bytes sampled with `cmd_first` low while no frame is open produce no pulse and leave `wr_addr` and `wr_data` unchanged.
- R9: With FRAME_BYTES below 6, data bits at and above 8*(FRAME_BYTES-2) read as zero.
- R10: `wr_addr` equals address[LOC_W-1:0] of the most recently completed frame. `wr_addr` and `wr_data` change only in the cycle where a frame's result appears, whether or not any window matched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_byte | input | 8 | Byte offered on the link this cycle |
| cmd_first | input | 1 | Marks `cmd_byte` as byte 0 of a new frame |
| wr_addr | output | LOC_W (4) | Low address bits of the last completed frame |
| wr_data | output | 32 | Data word of the last completed frame |
| wr_en | output | NUM_WIN (2) | One-cycle write enable, one bit per window |

## Verification
The bench instantiates the decoder twice. Both instances use two overlapping windows. Window 0 is base 0x1200 with mask 0xFF00, and window 1 is base 0x00A0 with mask 0x00F0. Addresses such as 0x12A5 hit both windows, 0x1201 hits only window 0, 0x34A7 hits only window 1, and 0x3344 hits neither. This brings the independent-decode and no-match cases within reach. The main instance uses the full 6-byte frame and is used for frame restarts, idle noise, back-to-back frames and random traffic. The second instance uses FRAME_BYTES=4, which exposes the zeroing of the two missing upper data bytes.

// File: rtl/cmdser_pkg.sv
`timescale 1ns/1ps
package cmdser_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int MIN_FRAME = 3;
  localparam int MAX_FRAME = 2 + DATA_W / BYTE_W;

  typedef logic [ADDR_W-1:0] cmd_addr_t;
  typedef logic [DATA_W-1:0] cmd_data_t;

  // one assembled frame as handed from the framer to the output stage
  typedef struct packed {
    logic      done;
    cmd_addr_t addr;
    cmd_data_t data;
  } frame_t;

  function automatic logic window_hit(cmd_addr_t a, cmd_addr_t base, cmd_addr_t mask);
    return ((a & mask) == (base & mask));
  endfunction
endpackage

// File: rtl/cmdser_framer.sv
`timescale 1ns/1ps
module cmdser_framer
  import cmdser_pkg::*;
#(
  parameter int FRAME_BYTES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              first_i,
  output frame_t            frame_o
);
  localparam int CNT_W      = $clog2(FRAME_BYTES + 1);
  localparam int DATA_LANES = FRAME_BYTES - 2;

  if (FRAME_BYTES < MIN_FRAME || FRAME_BYTES > MAX_FRAME) begin : g_bad_len
    $error("cmdser_framer: FRAME_BYTES out of range");
  end

  // cnt == 0: no frame open; cnt == k: next byte is frame byte k
  logic [CNT_W-1:0] cnt;
  frame_t           fr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      fr  <= '0;
    end else begin
      fr.done <= 1'b0;
      if (first_i) begin
        // a start flag always wins: any open frame is abandoned
        fr.addr <= {{(ADDR_W-BYTE_W){1'b0}}, byte_i};
        fr.data <= '0;
        cnt     <= CNT_W'(1);
      end else if (cnt != '0) begin
        if (cnt == CNT_W'(1)) fr.addr[ADDR_W-1:BYTE_W] <= byte_i;
        for (int k = 0; k < DATA_LANES; k++) begin
          if (cnt == CNT_W'(k + 2)) fr.data[BYTE_W*k +: BYTE_W] <= byte_i;
        end
        if (cnt == CNT_W'(FRAME_BYTES - 1)) begin
          cnt     <= '0;
          fr.done <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign frame_o = fr;
endmodule

// File: rtl/cmdser_window.sv
`timescale 1ns/1ps
module cmdser_window
  import cmdser_pkg::*;
#(
  parameter cmd_addr_t BASE = '0,
  parameter cmd_addr_t MASK = '0
) (
  input  cmd_addr_t addr_i,
  output logic      hit_o
);
  assign hit_o = window_hit(addr_i, BASE, MASK);
endmodule

// File: rtl/cmdser_outreg.sv
`timescale 1ns/1ps
module cmdser_outreg
  import cmdser_pkg::*;
#(
  parameter int LOC_W   = 4,
  parameter int NUM_WIN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  frame_t             frame_i,
  input  logic [NUM_WIN-1:0] hit_i,
  output logic [LOC_W-1:0]   loc_o,
  output cmd_data_t          data_o,
  output logic [NUM_WIN-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      loc_o  <= '0;
      data_o <= '0;
      en_o   <= '0;
    end else begin
      en_o <= frame_i.done ? hit_i : '0;
      if (frame_i.done) begin
        loc_o  <= frame_i.addr[LOC_W-1:0];
        data_o <= frame_i.data;
      end
    end
  end
endmodule

// File: rtl/cmd_byte_decoder.sv
`timescale 1ns/1ps
module cmd_byte_decoder
  import cmdser_pkg::*;
#(
  parameter int                        FRAME_BYTES = 6,
  parameter int                        LOC_W       = 4,
  parameter int                        NUM_WIN     = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASE    = {16'h0738, 16'h0730},
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_MASK    = {16'hFFFE, 16'hFFF8}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         cmd_byte,
  input  logic               cmd_first,
  output logic [LOC_W-1:0]   wr_addr,
  output logic [31:0]        wr_data,
  output logic [NUM_WIN-1:0] wr_en
);
  frame_t             frame;
  logic [NUM_WIN-1:0] hits;

  cmdser_framer #(.FRAME_BYTES(FRAME_BYTES)) u_framer (
    .clk     (clk),
    .rst     (rst),
    .byte_i  (cmd_byte),
    .first_i (cmd_first),
    .frame_o (frame)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    cmdser_window #(
      .BASE (WIN_BASE[w*ADDR_W +: ADDR_W]),
      .MASK (WIN_MASK[w*ADDR_W +: ADDR_W])
    ) u_win (
      .addr_i (frame.addr),
      .hit_o  (hits[w])
    );
  end

  cmdser_outreg #(.LOC_W(LOC_W), .NUM_WIN(NUM_WIN)) u_out (
    .clk     (clk),
    .rst     (rst),
    .frame_i (frame),
    .hit_i   (hits),
    .loc_o   (wr_addr),
    .data_o  (wr_data),
    .en_o    (wr_en)
  );
endmodule

// File: rtl/cmd_byte_decoder_chk.sv
`timescale 1ns/1ps
module cmd_byte_decoder_chk
  import cmdser_pkg::*;
#(
  parameter int                        FRAME_BYTES = 6,
  parameter int                        LOC_W       = 4,
  parameter int                        NUM_WIN     = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASE    = '0,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_MASK    = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [7:0]         cmd_byte,
  input logic               cmd_first,
  input logic [LOC_W-1:0]   wr_addr,
  input logic [31:0]        wr_data,
  input logic [NUM_WIN-1:0] wr_en
);
  // port-side tracking of frames, independent of the framer's state
  int unsigned        pos;
  logic               fin;
  cmd_addr_t          cur_addr;
  cmd_addr_t          fin_addr;
  logic [NUM_WIN-1:0] want;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= 0;
      fin      <= 1'b0;
      cur_addr <= '0;
      fin_addr <= '0;
    end else begin
      fin <= 1'b0;
      if (cmd_first) begin
        pos      <= 1;
        cur_addr <= {8'h00, cmd_byte};
      end else if (pos != 0) begin
        if (pos == 1) cur_addr[15:8] <= cmd_byte;
        if (pos == FRAME_BYTES - 1) begin
          pos      <= 0;
          fin      <= 1'b1;
          fin_addr <= cur_addr;
        end else begin
          pos <= pos + 1;
        end
      end
    end
  end

  always_comb begin
    for (int w = 0; w < NUM_WIN; w++)
      want[w] = window_hit(fin_addr, WIN_BASE[w*ADDR_W +: ADDR_W], WIN_MASK[w*ADDR_W +: ADDR_W]);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (wr_en == '0));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|wr_en) |=> (wr_en == '0));

  // R6
  pulse_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (|wr_en) |-> $past(fin));

  // R3
  window_decode_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fin) |-> (wr_en == want));

  // R10
  low_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fin) |-> (wr_addr == fin_addr[LOC_W-1:0]));

  // R8
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(fin) |-> ($stable(wr_data) && $stable(wr_addr)));
endmodule

bind cmd_byte_decoder cmd_byte_decoder_chk #(
  .FRAME_BYTES (FRAME_BYTES),
  .LOC_W       (LOC_W),
  .NUM_WIN     (NUM_WIN),
  .WIN_BASE    (WIN_BASE),
  .WIN_MASK    (WIN_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_byte  (cmd_byte),
  .cmd_first (cmd_first),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_en     (wr_en)
);

// File: tb/cmd_byte_decoder_test.sv
`timescale 1ns/1ps
module cmd_byte_decoder_test;
  localparam logic [15:0] B0 = 16'h1200, M0 = 16'hFF00;
  localparam logic [15:0] B1 = 16'h00A0, M1 = 16'h00F0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmd_byte = 8'h00;
  logic        cmd_first = 1'b0;
  logic [3:0]  wr_addr, wr_addr_s;
  logic [31:0] wr_data, wr_data_s;
  logic [1:0]  wr_en, wr_en_s;

  int checks = 0, errors = 0, pulses = 0, cycles = 0;

  cmd_byte_decoder #(
    .FRAME_BYTES(6), .LOC_W(4), .NUM_WIN(2),
    .WIN_BASE({B1, B0}), .WIN_MASK({M1, M0})
  ) uut (
    .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_first(cmd_first),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en)
  );

  cmd_byte_decoder #(
    .FRAME_BYTES(4), .LOC_W(4), .NUM_WIN(2),
    .WIN_BASE({B1, B0}), .WIN_MASK({M1, M0})
  ) uut_short (
    .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_first(cmd_first),
    .wr_addr(wr_addr_s), .wr_data(wr_data_s), .wr_en(wr_en_s)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst && (|wr_en)) pulses++;
    cycles++;
    if (cycles > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=below 50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [1:0] exp_hits(logic [15:0] a);
    return {((a & M1) == (B1 & M1)), ((a & M0) == (B0 & M0))};
  endfunction

  function automatic string hit_tag(logic [1:0] h);
    if (h == 2'b11) return "R4";
    if (h == 2'b00) return "R5";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives nb frame bytes on consecutive cycles, no trailing idle
  task automatic send(logic [15:0] a, logic [31:0] d, int nb);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      cmd_first = (i == 0);
      if (i == 0)      cmd_byte = a[7:0];
      else if (i == 1) cmd_byte = a[15:8];
      else             cmd_byte = 8'(d >> (8 * (i - 2)));
    end
  endtask

  task automatic idle_noise(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_first = 1'b0;
      cmd_byte  = 8'($urandom);
    end
  endtask

  // full 6-byte frame on uut, result checked in the cycle after edge n+1
  task automatic cmd_main(logic [15:0] a, logic [31:0] d);
    logic [1:0] h;
    h = exp_hits(a);
    send(a, d, 6);
    idle_noise(1);             // edge n: last byte sampled
    @(negedge clk);            // edge n+1: result registered
    chk(hit_tag(h), 32'(wr_en), 32'(h));
    chk("R10", 32'(wr_addr), 32'(a[3:0]));
    chk("R2", wr_data, d);
    @(negedge clk);            // edge n+2: pulse over
    chk("R6", 32'(wr_en), 32'd0);
  endtask

  task automatic cmd_short(logic [15:0] a, logic [31:0] d);
    logic [1:0] h;
    h = exp_hits(a);
    send(a, d, 4);
    @(negedge clk);
    cmd_first = 1'b0;
    cmd_byte  = 8'h00;
    @(negedge clk);
    chk(hit_tag(h), 32'(wr_en_s), 32'(h));
    chk("R9", wr_data_s, {16'h0000, d[15:0]});
    @(negedge clk);
    chk("R6", 32'(wr_en_s), 32'd0);
  endtask

  initial begin
    int p;
    logic [31:0] dsave;
    logic [3:0]  asave;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    chk("R1", 32'(wr_en), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 32'(wr_en), 32'd0);
    chk("R1", 32'(wr_addr), 32'd0);
    chk("R1", wr_data, 32'd0);

    // short-frame instance: upper data bytes must be zero
    cmd_short(16'h12A3, 32'hCAFEF00D);
    cmd_short(16'h3344, 32'h89ABCDEF);
    for (int i = 0; i < 10; i++) cmd_short(16'($urandom), $urandom);
    cmd_first = 1'b0;
    cmd_byte  = 8'h00;
    repeat (8) @(negedge clk);

    // directed window cases on the 6-byte instance
    cmd_main(16'h12A5, 32'hDEADBEEF);   // both windows
    cmd_main(16'h1201, 32'h01234567);   // window 0 only
    cmd_main(16'h34A7, 32'h76543210);   // window 1 only
    cmd_main(16'h3344, 32'hA5A55A5A);   // neither
    cmd_main(16'h12FF, 32'h0000FFFF);   // top of window 0
    cmd_main(16'h11AF, 32'hFFFF0000);   // edge of window 1 only

    // R8: stray bytes while idle
    repeat (3) @(negedge clk);
    p = pulses; dsave = wr_data; asave = wr_addr;
    idle_noise(30);
    repeat (3) @(negedge clk);
    chk("R8", 32'(pulses), 32'(p));
    chk("R8", wr_data, dsave);
    chk("R8", 32'(wr_addr), 32'(asave));

    // R7: frame cut after 3 bytes, then after 5 bytes (last byte due)
    p = pulses;
    send(16'h12A1, 32'h11111111, 3);
    cmd_main(16'h1202, 32'h22222222);
    send(16'h12A3, 32'h33333333, 5);
    cmd_main(16'h34A4, 32'h44444444);
    repeat (2) @(negedge clk);
    chk("R7", 32'(pulses), 32'(p + 2));

    // R6: back-to-back frames, one pulse each
    p = pulses;
    send(16'h12A6, 32'h55555555, 6);
    send(16'h12A7, 32'h66666666, 6);
    cmd_first = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6", 32'(pulses), 32'(p + 2));
    chk("R2", wr_data, 32'h66666666);
    chk("R10", 32'(wr_addr), 32'h7);

    // random traffic
    for (int i = 0; i < 150; i++) begin
      logic [15:0] a;
      case ($urandom % 4)
        0:       a = {8'h12, 8'($urandom)};
        1:       a = {8'($urandom), 4'hA, 4'($urandom)};
        2:       a = {12'h12A, 4'($urandom)};
        default: a = 16'($urandom);
      endcase
      idle_noise($urandom % 4);
      cmd_main(a, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule